// File: doc/BRIEF.md
# Interlocked Read Responder for a Shared Address/Data Bus

This block is the memory end of a fully interlocked, four-phase read exchange carried over one set of lines that holds first an address and then a data word. A requester announces a read with a request strobe while presenting the address. The responder captures the address and acknowledges. It waits for the request to go away, then drops its acknowledge. It looks the word up in an internal store, then presents it with a data-ready strobe. It keeps that strobe and the word in place until the requester acknowledges receipt, releases the lines, and waits for the requester's acknowledge to fall before it will accept anything new.

The requester's two strobes arrive from another timing domain. Each one passes through a two-stage synchroniser before the sequencer uses it. Bus drive is modelled as a separate output word and output enable, so that a wrapper or pad ring can build the shared lines. The fetch latency is a parameter given in clock cycles. The word store is preloaded from a closed-form pattern and has a registered read port.

Top module: `hsr_responder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ack_out`, `drdy_out` and `bus_oe` are all low.
- R8: Each requester strobe goes through two synchroniser flops, and the sequencer registers its response one edge later. A change on `req_in` or `ack_in` therefore shows as the responder's reaction after the third rising clock edge.
- R2: In idle, a high synchronised request (with the requester acknowledge low) captures the address from `bus_in` and raises `ack_out`. `bus_oe` stays low for as long as `ack_out` is high.
- R3: `ack_out` stays high while the synchronised request is high. It falls on the edge where the request is seen low.
- R4: `drdy_out` rises exactly LATENCY clock cycles after `ack_out` falls, with `bus_oe` high at the same time.
- R5: The word driven on `bus_out` for address a is (a*WORD_MUL + WORD_OFS) mod 2^DW, with defaults WORD_MUL=40503 and WORD_OFS=4660. The address is `bus_in[AW-1:0]` (AW=6). The upper bits of `bus_in` are ignored.
- R6: `drdy_out`, `bus_oe` and `bus_out` hold steady until the requester acknowledge is seen high. `drdy_out` and `bus_oe` then fall on the same edge.
- R7: A request raised before the requester acknowledge has been seen low is ignored: `ack_out` stays low. Once the acknowledge has been seen low, the block returns to idle and serves the pending request, with `ack_out` rising after the fourth edge that follows the acknowledge falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Requester read strobe, asynchronous |
| ack_in | input | 1 | Requester receipt acknowledge, asynchronous |
| bus_in | input | DW | Shared lines as seen by the responder (address phase) |
| bus_out | output | DW | Word the responder drives during the data phase |
| bus_oe | output | 1 | Responder drive enable for the shared lines |
| ack_out | output | 1 | Responder acknowledge of the address |
| drdy_out | output | 1 | Data-ready strobe |

## Verification
If the sequencer is in the wrong state, a strobe arrives early, late or never. The bench counts edges from each requester action to the responder's answer, so a single lost or extra cycle in the synchroniser, the latency counter or a state shows up on the very transaction where it happens. A wrong captured address or a bad store read shows up as a data miscompare at the rising edge of `drdy_out`. A broken busy interlock shows up as an acknowledge during the window where the requester still holds its own acknowledge high.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_FETCH,
    ST_DRIVE,
    ST_CLOSE
  } hsr_state_e;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsr_store.sv
module hsr_store #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int WORD_MUL = 40503,
  parameter int WORD_OFS = 4660
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * WORD_MUL + WORD_OFS);
  end

  always_ff @(posedge clk) rd_data <= mem[rd_addr];
endmodule

// File: rtl/hsr_ctrl.sv
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int LATENCY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_s,
  input  logic          ack_s,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          ack_out,
  output logic          drdy_out,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);
  localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  hsr_state_e    state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;

  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_out  <= 1'b0;
      drdy_out <= 1'b0;
      bus_oe   <= 1'b0;
      bus_out  <= '0;
      addr_q   <= '0;
      cnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_s && !ack_s) begin
          addr_q  <= addr_in;
          ack_out <= 1'b1;
          state   <= ST_ADDR;
        end
        ST_ADDR: if (!req_s) begin
          ack_out <= 1'b0;
          cnt     <= '0;
          state   <= ST_FETCH;
        end
        ST_FETCH: if (cnt == LAST) begin
          bus_out  <= rd_data;
          bus_oe   <= 1'b1;
          drdy_out <= 1'b1;
          state    <= ST_DRIVE;
        end else begin
          cnt <= cnt + CW'(1);
        end
        ST_DRIVE: if (ack_s) begin
          drdy_out <= 1'b0;
          bus_oe   <= 1'b0;
          state    <= ST_CLOSE;
        end
        ST_CLOSE: if (!ack_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_DRIVE_IN_ADDR: assert property (@(posedge clk) disable iff (rst)
    ack_out |-> !bus_oe); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_out && req_s) |=> ack_out); // R3
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack_out && drdy_out)); // R4
  AST_DRDY_WAIT: assert property (@(posedge clk) disable iff (rst)
    (drdy_out && !ack_s) |=> (drdy_out && bus_oe)); // R6
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (drdy_out && $past(drdy_out)) |-> $stable(bus_out)); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLOSE && ack_s) |=> !ack_out); // R7
endmodule

// File: rtl/hsr_responder.sv
module hsr_responder #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int LATENCY  = 4,
  parameter int WORD_MUL = 40503,
  parameter int WORD_OFS = 4660
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_in,
  input  logic          ack_in,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          ack_out,
  output logic          drdy_out
);
  logic [1:0]    strobes_s;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          unused_hi;

  assign unused_hi = ^bus_in[DW-1:AW];

  hsr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ack_in, req_in}),
    .q   (strobes_s)
  );

  hsr_store #(.AW(AW), .DW(DW), .WORD_MUL(WORD_MUL), .WORD_OFS(WORD_OFS)) u_store (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  hsr_ctrl #(.AW(AW), .DW(DW), .LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_s    (strobes_s[0]),
    .ack_s    (strobes_s[1]),
    .addr_in  (bus_in[AW-1:0]),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ack_out  (ack_out),
    .drdy_out (drdy_out),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );
endmodule

// File: tb/hsr_responder_tb.sv
module hsr_responder_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LATENCY = 4;
  localparam int WORD_MUL = 40503;
  localparam int WORD_OFS = 4660;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_in = 1'b0;
  logic ack_in = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic bus_oe, ack_out, drdy_out;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] exp_q [$];
  logic prev_drdy = 1'b0;

  always #5 clk = ~clk;

  hsr_responder #(.AW(AW), .DW(DW), .LATENCY(LATENCY),
                  .WORD_MUL(WORD_MUL), .WORD_OFS(WORD_OFS)) u_dut (
    .clk(clk), .rst(rst), .req_in(req_in), .ack_in(ack_in), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ack_out(ack_out), .drdy_out(drdy_out)
  );

  function automatic logic [DW-1:0] word_at(input logic [DW-1:0] a);
    int ai;
    ai = int'(a[AW-1:0]);
    return DW'(ai * WORD_MUL + WORD_OFS);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected word at each rising data-ready strobe (R5)
  always @(negedge clk) begin
    if (!rst && drdy_out && !prev_drdy) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", int'(bus_out), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(bus_out == e && bus_oe, "R5 data word", int'(bus_out), int'(e));
      end
    end
    prev_drdy <= drdy_out;
  end

  task automatic wait_cnt(input logic want, input int sel, output int n);
    n = 0;
    while ((sel == 0 ? ack_out : drdy_out) != want) begin
      @(negedge clk);
      n++;
    end
  endtask

  // early=1: the request is already up and the acknowledge was just dropped
  task automatic read_word(input logic [DW-1:0] a, input bit early, input bit keep_ack);
    int n;
    if (!early) begin
      exp_q.push_back(word_at(a));
      @(negedge clk);
      req_in = 1'b1;
      bus_in = a;
      wait_cnt(1'b1, 0, n);
      chk(n == 3, "R8 req to ack edges", n, 3);
    end else begin
      wait_cnt(1'b1, 0, n);
      chk(n == 4, "R7 pending req served", n, 4);
    end
    chk(bus_oe == 1'b0, "R2 no drive while ack", int'(bus_oe), 0);
    repeat (2) @(negedge clk);
    chk(ack_out == 1'b1, "R3 ack held", int'(ack_out), 1);
    req_in = 1'b0;
    bus_in = 16'hA5C3;
    wait_cnt(1'b0, 0, n);
    chk(n == 3, "R3 ack drop edges", n, 3);
    wait_cnt(1'b1, 1, n);
    chk(n == LATENCY, "R4 latency", n, LATENCY);
    chk(bus_oe == 1'b1, "R4 oe with drdy", int'(bus_oe), 1);
    begin
      logic [DW-1:0] held;
      held = bus_out;
      repeat (4) @(negedge clk);
      chk(drdy_out && bus_oe && bus_out == held, "R6 hold until ack",
          int'(bus_out), int'(held));
    end
    ack_in = 1'b1;
    wait_cnt(1'b0, 1, n);
    chk(n == 3 && bus_oe == 1'b0, "R6 release edges", n, 3);
    if (!keep_ack) begin
      ack_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack_out && !drdy_out && !bus_oe, "R1 reset state",
        int'({ack_out, drdy_out, bus_oe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ack_out && !drdy_out && !bus_oe, "R1 after reset",
        int'({ack_out, drdy_out, bus_oe}), 0);
    read_word(16'd0, 1'b0, 1'b0);
    read_word(16'd63, 1'b0, 1'b0);
    read_word(16'd5, 1'b0, 1'b0);
    read_word(16'hFFC5, 1'b0, 1'b0);   // R5 upper bits ignored -> word of 5
    read_word(16'd21, 1'b0, 1'b1);
    // R7: new request while requester acknowledge still high
    exp_q.push_back(word_at(16'd42));
    req_in = 1'b1;
    bus_in = 16'd42;
    repeat (8) @(negedge clk);
    chk(ack_out == 1'b0, "R7 request ignored", int'(ack_out), 0);
    ack_in = 1'b0;
    read_word(16'd42, 1'b1, 1'b0);
    read_word(16'd1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule